// File: doc/BRIEF.md
# Codec Frame-Sync Serial Port

A synchronous serial port for audio codecs. A frame opens with a frame-sync pulse one bit-clock period wide. One or more data words follow it back to back, most significant bit first, starting in the bit period right after the pulse. The port can produce the bit clock and the frame sync itself, or it can follow a bit clock and a frame sync supplied on its pins. The two choices are made separately.

The host supplies the next transmit word on a parallel bus. The port copies it at every word boundary and marks the copy with a one-cycle strobe. Each received word is presented right-justified with a one-cycle valid strobe. Several things are configurable: the word size (coded as size minus one), the number of words per frame, the frame length in bit periods when the port makes the frame sync, and the bit-clock edge on which data is sampled. Data is launched on the opposite edge. All pins are handled in the single system clock domain; external pins pass through two-stage synchronizers.

Top module: `codec_serial_port`

## Requirements
- R1: With `cfg_fs_master`=1, `fs_out` is high for exactly one bit-clock period per frame.
- R2: With `cfg_fs_master`=1, successive rises of `fs_out` are `cfg_frame_m1`+1 bit periods apart.
- R3: The MSB of word 0 occupies the bit period right after the frame-sync period. Exactly `cfg_words_m1`+1 words follow back to back in each frame.
- R4: A word is `cfg_ws_m1`+1 bits long. Transmit sends `tx_word[cfg_ws_m1:0]` MSB first, and the value 15 selects 16 bits.
- R5: With `cfg_rise_sample`=0, data and frame sync are sampled on the falling bit-clock edge and `sdo` changes only on the rising edge. With 1, the edges are swapped.
- R6: Bit periods after the last word of a frame keep `sdo` low, and `sdi` in those periods produces no received word.
- R7: `rx_valid` pulses for one system clock after the LSB of a word is sampled. `rx_word` then holds the word right-justified, with the upper bits zero.
- R8: `tx_take` pulses for one system clock each time `tx_word` is copied at a word boundary. The k-th copy is the k-th word transmitted.
- R9: With `cfg_fs_master`=0 and `cfg_clk_master`=0, framing follows `fs_in` sampled on `sclk_in`. With `cfg_clk_master`=1, the port drives `sclk_out` with a period of 2·CLK_HALF system clocks.
- R10: A frame-sync pulse that arrives inside a frame restarts the frame. A word cut short produces no `rx_valid`, while a word whose LSB coincides with the pulse is still delivered.
- R11: During reset, `sclk_out`, `fs_out`, `sdo`, `tx_take`, `rx_valid` and `rx_word` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fs_master | input | 1 | 1: generate frame sync; 0: take it from `fs_in` |
| cfg_clk_master | input | 1 | 1: generate bit clock; 0: use `sclk_in` |
| cfg_rise_sample | input | 1 | 0: sample on falling edge; 1: sample on rising edge |
| cfg_ws_m1 | input | 4 | Word size minus one |
| cfg_words_m1 | input | 3 | Words per frame minus one |
| cfg_frame_m1 | input | 9 | Frame length in bit periods minus one (master sync) |
| sclk_in | input | 1 | External bit clock |
| fs_in | input | 1 | External frame sync |
| sdi | input | 1 | Serial receive data |
| sclk_out | output | 1 | Generated bit clock |
| fs_out | output | 1 | Generated frame sync |
| sdo | output | 1 | Serial transmit data |
| tx_word | input | 16 | Next word to transmit |
| tx_take | output | 1 | Strobe: `tx_word` copied |
| rx_word | output | 16 | Last received word, right-justified |
| rx_valid | output | 1 | Strobe: `rx_word` updated |

## Verification
Two events can land on the same sample edge in follower mode: a frame-sync pulse and the capture of a word's last bit. In that case the word must still be delivered and the next launch edge must restart the frame. The bench provokes this by raising `fs_in` in the LSB period of a word. A second case raises it halfway through a word. The bench then counts `rx_valid` strobes against its own list of expected words and checks `sdo` bit by bit in the restarted frame against the words taken.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

    parameter int DW   = 16;
    parameter int WS_W = $clog2(DW);
    parameter int NW_W = 3;
    parameter int FL_W = 9;

    typedef struct packed {
        logic            fs_master;
        logic            clk_master;
        logic            rise_sample;
        logic [WS_W-1:0] ws_m1;
        logic [NW_W-1:0] words_m1;
        logic [FL_W-1:0] frame_m1;
    } ccs_cfg_t;

    typedef struct packed {
        logic sample;
        logic launch;
    } bclk_ev_t;

    function automatic logic [DW-1:0] word_mask(input logic [WS_W-1:0] ws_m1);
        logic [DW-1:0] m;
        for (int i = 0; i < DW; i++) begin
            m[i] = (i <= int'(ws_m1));
        end
        return m;
    endfunction

endpackage

// File: rtl/ccs_edge_gen.sv
module ccs_edge_gen
    import ccs_pkg::*;
#(
    parameter int CLK_HALF = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     clk_master,
    input  logic     rise_sample,
    input  logic     sclk_in,
    input  logic     fs_in,
    input  logic     sdi,
    output logic     sclk_out,
    output bclk_ev_t ev,
    output logic     fs_s,
    output logic     sdi_s
);

    localparam int CW    = $clog2(CLK_HALF + 1);
    localparam int NPIN  = 3;

    logic [CW-1:0]   cnt;
    logic            sclk_r;
    logic [NPIN-1:0] pin_raw, sy1, sy2;
    logic            sc_prev;
    logic            tick, rise, fall;

    assign pin_raw = {sdi, fs_in, sclk_in};

    for (genvar p = 0; p < NPIN; p++) begin : g_sync
        always_ff @(posedge clk) begin
            if (rst) begin
                sy1[p] <= 1'b0;
                sy2[p] <= 1'b0;
            end else begin
                sy1[p] <= pin_raw[p];
                sy2[p] <= sy1[p];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            sclk_r  <= 1'b0;
            sc_prev <= 1'b0;
        end else begin
            sc_prev <= sy2[0];
            if (clk_master) begin
                if (tick) begin
                    cnt    <= '0;
                    sclk_r <= ~sclk_r;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end else begin
                cnt    <= '0;
                sclk_r <= 1'b0;
            end
        end
    end

    always_comb begin
        tick      = clk_master && (cnt == CW'(CLK_HALF - 1));
        rise      = clk_master ? (tick && !sclk_r) : (sy2[0] && !sc_prev);
        fall      = clk_master ? (tick && sclk_r)  : (!sy2[0] && sc_prev);
        ev.sample = rise_sample ? rise : fall;
        ev.launch = rise_sample ? fall : rise;
    end

    assign sclk_out = sclk_r;
    assign fs_s     = sy2[1];
    assign sdi_s    = sy2[2];

    AST_EDGE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ev.sample && ev.launch)); // R5

endmodule

// File: rtl/ccs_frame_ctrl.sv
module ccs_frame_ctrl
    import ccs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  ccs_cfg_t        cfg,
    input  bclk_ev_t        ev,
    input  logic            fs_s,
    input  logic [DW-1:0]   tx_word,
    output logic            fs_out,
    output logic            sdo,
    output logic            tx_take,
    output logic            in_data,
    output logic [WS_W-1:0] bit_idx
);

    logic [FL_W-1:0] pos, pos_nx;
    logic            sync_seen;
    logic [NW_W-1:0] word_q;
    logic [DW-1:0]   cur_q;
    logic [WS_W-1:0] nidx;
    logic            master_wrap;

    always_comb begin
        pos_nx      = sync_seen ? FL_W'(1)
                    : ((pos >= cfg.frame_m1) ? '0 : pos + 1'b1);
        master_wrap = cfg.fs_master && (pos_nx == '0);
        nidx        = cfg.ws_m1 - bit_idx - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos       <= '1;
            sync_seen <= 1'b0;
            fs_out    <= 1'b0;
            sdo       <= 1'b0;
            tx_take   <= 1'b0;
            in_data   <= 1'b0;
            bit_idx   <= '0;
            word_q    <= '0;
            cur_q     <= '0;
        end else begin
            tx_take <= 1'b0;
            if (ev.sample) begin
                sync_seen <= cfg.fs_master ? fs_out : fs_s;
            end
            if (ev.launch) begin
                pos       <= pos_nx;
                fs_out    <= master_wrap;
                sync_seen <= 1'b0;
                if (sync_seen) begin
                    in_data <= 1'b1;
                    bit_idx <= '0;
                    word_q  <= '0;
                    cur_q   <= tx_word;
                    sdo     <= tx_word[cfg.ws_m1];
                    tx_take <= 1'b1;
                end else if (master_wrap) begin
                    in_data <= 1'b0;
                    sdo     <= 1'b0;
                end else if (in_data) begin
                    if (bit_idx == cfg.ws_m1) begin
                        if (word_q == cfg.words_m1) begin
                            in_data <= 1'b0;
                            sdo     <= 1'b0;
                        end else begin
                            word_q  <= word_q + 1'b1;
                            bit_idx <= '0;
                            cur_q   <= tx_word;
                            sdo     <= tx_word[cfg.ws_m1];
                            tx_take <= 1'b1;
                        end
                    end else begin
                        bit_idx <= bit_idx + 1'b1;
                        sdo     <= cur_q[nidx];
                    end
                end
            end
        end
    end

    AST_FS_ONE_PERIOD: assert property (@(posedge clk) disable iff (rst)
        (ev.launch && fs_out && cfg.fs_master && cfg.frame_m1 != '0) |=> !fs_out); // R1

    AST_IDLE_SDO_LOW: assert property (@(posedge clk) disable iff (rst)
        (ev.launch && !in_data && !sync_seen) |=> !sdo); // R6

    AST_TAKE_ON_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        tx_take |-> $past(ev.launch)); // R8

    AST_BIT_IN_WORD: assert property (@(posedge clk) disable iff (rst)
        in_data |-> (bit_idx <= cfg.ws_m1)); // R4

endmodule

// File: rtl/ccs_rx_shift.sv
module ccs_rx_shift
    import ccs_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            sample,
    input  logic            in_data,
    input  logic [WS_W-1:0] bit_idx,
    input  logic [WS_W-1:0] ws_m1,
    input  logic            sdi_s,
    output logic [DW-1:0]   rx_word,
    output logic            rx_valid
);

    logic [DW-1:0] sh;
    logic [DW-1:0] sh_nx;

    assign sh_nx = {sh[DW-2:0], sdi_s};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh       <= '0;
            rx_word  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (sample && in_data) begin
                sh <= sh_nx;
                if (bit_idx == ws_m1) begin
                    rx_word  <= sh_nx & word_mask(ws_m1);
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    AST_RX_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rx_valid |=> !rx_valid); // R7

endmodule

// File: rtl/codec_serial_port.sv
module codec_serial_port
    import ccs_pkg::*;
#(
    parameter int CLK_HALF = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_fs_master,
    input  logic            cfg_clk_master,
    input  logic            cfg_rise_sample,
    input  logic [WS_W-1:0] cfg_ws_m1,
    input  logic [NW_W-1:0] cfg_words_m1,
    input  logic [FL_W-1:0] cfg_frame_m1,
    input  logic            sclk_in,
    input  logic            fs_in,
    input  logic            sdi,
    output logic            sclk_out,
    output logic            fs_out,
    output logic            sdo,
    input  logic [DW-1:0]   tx_word,
    output logic            tx_take,
    output logic [DW-1:0]   rx_word,
    output logic            rx_valid
);

    ccs_cfg_t        cfg;
    bclk_ev_t        ev;
    logic            fs_s, sdi_s, in_data;
    logic [WS_W-1:0] bit_idx;

    always_comb begin
        cfg.fs_master   = cfg_fs_master;
        cfg.clk_master  = cfg_clk_master;
        cfg.rise_sample = cfg_rise_sample;
        cfg.ws_m1       = cfg_ws_m1;
        cfg.words_m1    = cfg_words_m1;
        cfg.frame_m1    = cfg_frame_m1;
    end

    ccs_edge_gen #(.CLK_HALF(CLK_HALF)) u_edge (
        .clk(clk), .rst(rst), .clk_master(cfg.clk_master),
        .rise_sample(cfg.rise_sample), .sclk_in(sclk_in), .fs_in(fs_in),
        .sdi(sdi), .sclk_out(sclk_out), .ev(ev), .fs_s(fs_s), .sdi_s(sdi_s)
    );

    ccs_frame_ctrl u_frame (
        .clk(clk), .rst(rst), .cfg(cfg), .ev(ev), .fs_s(fs_s),
        .tx_word(tx_word), .fs_out(fs_out), .sdo(sdo), .tx_take(tx_take),
        .in_data(in_data), .bit_idx(bit_idx)
    );

    ccs_rx_shift u_rx (
        .clk(clk), .rst(rst), .sample(ev.sample), .in_data(in_data),
        .bit_idx(bit_idx), .ws_m1(cfg.ws_m1), .sdi_s(sdi_s),
        .rx_word(rx_word), .rx_valid(rx_valid)
    );

endmodule

// File: tb/codec_serial_port_tb.sv
module codec_serial_port_tb_top;
    import ccs_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_fs_master = 1'b1, cfg_clk_master = 1'b1, cfg_rise_sample = 1'b0;
    logic [WS_W-1:0] cfg_ws_m1 = 4'd7;
    logic [NW_W-1:0] cfg_words_m1 = '0;
    logic [FL_W-1:0] cfg_frame_m1 = 9'd20;
    logic sclk_in = 1'b0, fs_in = 1'b0, sdi_drv = 1'b0, loop_en = 1'b0;
    logic sdi, sclk_out, fs_out, sdo, tx_take, rx_valid;
    logic [DW-1:0] tx_word, rx_word;

    int checks = 0, errors = 0;
    int tkn = 0, rxn = 0, exn = 0, fsn = 0, per = 0, rx_mark = 0;
    bit use_tk = 1'b1, mon_en = 1'b0, seen = 1'b0, fs_prev = 1'b0;
    logic sc_prev = 1'b0, sdo_prev = 1'b0;
    logic [DW-1:0] ex [0:255];

    always #5 clk = ~clk;

    function automatic logic [DW-1:0] pat(input int k);
        return 16'(k * 40503 + 12345);
    endfunction
    function automatic logic [DW-1:0] rpat(input int k);
        return 16'(k * 2731 + 777);
    endfunction
    function automatic logic [DW-1:0] msk(input int ws);
        return 16'((1 << ws) - 1);
    endfunction

    assign tx_word = pat(tkn);
    assign sdi     = loop_en ? sdo : sdi_drv;

    codec_serial_port dut_i (
        .clk(clk), .rst(rst), .cfg_fs_master(cfg_fs_master),
        .cfg_clk_master(cfg_clk_master), .cfg_rise_sample(cfg_rise_sample),
        .cfg_ws_m1(cfg_ws_m1), .cfg_words_m1(cfg_words_m1),
        .cfg_frame_m1(cfg_frame_m1), .sclk_in(sclk_in), .fs_in(fs_in),
        .sdi(sdi), .sclk_out(sclk_out), .fs_out(fs_out), .sdo(sdo),
        .tx_word(tx_word), .tx_take(tx_take), .rx_word(rx_word),
        .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: takes, received words, master framing
    always @(negedge clk) begin
        if (!rst) begin
            logic [DW-1:0] e;
            bit launch_tr;
            int ws, nd;
            ws = int'(cfg_ws_m1) + 1;
            nd = ws * (int'(cfg_words_m1) + 1);
            if (tx_take) tkn++;
            if (rx_valid) begin
                e = use_tk ? (pat(rxn) & msk(ws)) : ex[rxn];
                chk(rx_word == e, "R7/R4 rx_word", int'(rx_word), int'(e));
                rxn++;
            end
            if (mon_en) begin
                launch_tr = (sclk_out != sc_prev) && (sclk_out == !cfg_rise_sample);
                if (sdo != sdo_prev)
                    chk(launch_tr, "R5 sdo changed off launch edge", int'(sclk_out), int'(!cfg_rise_sample));
                if (launch_tr) begin
                    if (fs_out) begin
                        chk(!fs_prev, "R1 fs_out width", 1, 0);
                        if (seen) begin
                            chk(per == int'(cfg_frame_m1), "R2 frame length", per, int'(cfg_frame_m1));
                            chk(rxn - rx_mark == int'(cfg_words_m1) + 1, "R3 words per frame",
                                rxn - rx_mark, int'(cfg_words_m1) + 1);
                        end
                        rx_mark = rxn;
                        per  = 0;
                        seen = 1'b1;
                        fsn++;
                    end else begin
                        per++;
                        if (seen && per > nd) chk(sdo == 1'b0, "R6 trailing sdo", int'(sdo), 0);
                    end
                    fs_prev = fs_out;
                end
            end
            sc_prev  = sclk_out;
            sdo_prev = sdo;
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        tkn = 0; rxn = 0; exn = 0; fsn = 0; per = 0; rx_mark = 0;
        seen = 1'b0; fs_prev = 1'b0; sc_prev = 1'b0; sdo_prev = 1'b0;
        rst = 1'b0;
    endtask

    task automatic run_master(input int ws_m1, input int wm1, input bit rise);
        int guard;
        cfg_fs_master = 1'b1; cfg_clk_master = 1'b1; cfg_rise_sample = rise;
        cfg_ws_m1 = WS_W'(ws_m1); cfg_words_m1 = NW_W'(wm1);
        cfg_frame_m1 = FL_W'((ws_m1 + 1) * (wm1 + 1) + 2);
        loop_en = 1'b1; use_tk = 1'b1; mon_en = 1'b1;
        do_reset();
        guard = 0;
        while (fsn < 4 && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        chk(fsn >= 4, "R9 master frames produced", fsn, 4);
        mon_en = 1'b0;
    endtask

    // one bit period driven on sclk_in; sdo sampled just before falling edge
    task automatic slot(input logic f, input logic d, output logic so);
        @(negedge clk);
        sclk_in = 1'b1; fs_in = f; sdi_drv = d;
        repeat (6) @(negedge clk);
        so = sdo;
        sclk_in = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic slave_frame(input int nw, input int ws, input int trail, input logic fsd);
        logic so;
        logic [DW-1:0] w, t;
        int tb, r0;
        tb = tkn;
        slot(1'b1, fsd, so);
        for (int k = 0; k < nw; k++) begin
            w = rpat(exn);
            ex[exn] = w & msk(ws);
            exn++;
            for (int i = 0; i < ws; i++) begin
                slot(1'b0, w[ws-1-i], so);
                t = pat(tb + k);
                chk(so == t[ws-1-i], "R3/R8/R9 slave sdo bit", int'(so), int'(t[ws-1-i]));
            end
        end
        r0 = rxn;
        for (int j = 0; j < trail; j++) begin
            slot(1'b0, 1'b1, so);
            chk(so == 1'b0, "R6 slave trailing sdo", int'(so), 0);
        end
        chk(rxn == r0, "R6 trailing sdi ignored", rxn, r0);
        chk(rxn == exn, "R9/R10 received count", rxn, exn);
    endtask

    task automatic slave_setup(input int ws_m1, input int wm1);
        cfg_fs_master = 1'b0; cfg_clk_master = 1'b0; cfg_rise_sample = 1'b0;
        cfg_ws_m1 = WS_W'(ws_m1); cfg_words_m1 = NW_W'(wm1);
        loop_en = 1'b0; use_tk = 1'b0; mon_en = 1'b0;
        sclk_in = 1'b0; fs_in = 1'b0; sdi_drv = 1'b0;
        do_reset();
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic so;
        logic [DW-1:0] w;
        // R11 reset state
        repeat (4) @(negedge clk);
        chk({sclk_out, fs_out, sdo, tx_take, rx_valid} == 5'b0, "R11 reset outputs",
            int'({sclk_out, fs_out, sdo, tx_take, rx_valid}), 0);
        chk(rx_word == '0, "R11 reset rx_word", int'(rx_word), 0);

        // master sweep: word sizes 4/8/16, one or three words, both edges (R1..R8)
        for (int e = 0; e < 2; e++)
            for (int s = 0; s < 3; s++)
                for (int n = 0; n < 2; n++)
                    run_master((4 << s) - 1, n * 2, e[0]);

        // follower sweep (R9)
        for (int s = 0; s < 3; s++)
            for (int n = 0; n < 3; n++) begin
                slave_setup((4 << s) - 1, n);
                slave_frame(n + 1, 4 << s, 3, 1'b0);
                slave_frame(n + 1, 4 << s, 2, 1'b0);
            end

        // R10 case 1: sync halfway through a word; partial word dropped
        slave_setup(7, 1);
        slot(1'b1, 1'b0, so);
        for (int i = 0; i < 4; i++) slot(1'b0, i[0], so);
        slave_frame(2, 8, 2, 1'b1);

        // R10 case 2: sync on the LSB period of a word; word kept, frame restarts
        slave_setup(7, 1);
        slot(1'b1, 1'b0, so);
        w = rpat(exn);
        ex[exn] = w & msk(8);
        exn++;
        for (int i = 7; i >= 1; i--) slot(1'b0, w[i], so);
        slave_frame(2, 8, 2, w[0]);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule